// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block lets a processor run a counted loop with no branch instruction at the bottom. It holds three loop registers: the loop begin address, the loop end address and a remaining-iteration count. A loop-setup command loads all three at once. Each later retiring instruction whose sequential successor address equals the loop end is checked. If iterations remain, the controller asks fetch to restart at the loop begin and decrements the count.

A setup command comes in three kinds. The plain kind always enters the loop. The other two kinds jump straight past the loop body when the source operand is zero, or when it is zero or negative as a signed value. The three registers can also be read and written as special registers. An exception-mode input suspends all loop-back behaviour while it is set.

All pins are plain control and data pins with no back-pressure. A setup command or a retire report is taken in the cycle where its valid pin is high. The redirect output is a registered single-cycle pulse, and fetch must act on it in that cycle.

Top module: `hwloop_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the begin, end and count registers to zero and drops the redirect output.
- R2: A setup command sets the end register to the command PC plus the 8-bit immediate (zero-extended) plus 4.
- R3: A setup command sets the begin register to the command's next sequential PC.
- R4: A setup command sets the count register to the source operand minus 1, wrapping modulo 2^32.
- R5: The setup kind is encoded as follows: 0 always enters the loop, 1 skips if the source is zero, 2 skips if the source is zero or negative as a signed value, and 3 behaves like 0. A skip produces a redirect in the next cycle whose target is the newly computed end address.
- R6: A retire report that is valid and not a taken branch, and whose next PC equals the end register, causes a loop-back when the count is nonzero and exception mode is clear. On a loop-back the count drops by one and, in the next cycle, the redirect pulses for one cycle with the begin register as target.
- R7: When the count is zero at the end address, no redirect is issued and the count keeps its value.
- R8: A retire report flagged as a taken branch or jump never causes a loop-back.
- R9: While exception mode is set, no loop-back occurs and the count is left unchanged.
- R10: The special-register numbers are 0 for begin, 1 for end and 2 for count, all readable and writable. Reading number 3 returns zero. A new value written to the end register is used by every later loop-end comparison.
- R11: If a setup skip and a loop-back occur in the same cycle, the redirect target is the skip target. The setup values also take precedence over the count decrement.
- R12: A special-register write takes precedence over both a setup load and a loop-back decrement of the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | Loop-setup command present |
| setup_kind | input | 2 | Setup kind (0 always, 1 skip-if-zero, 2 skip-if-not-positive) |
| setup_pc | input | 32 | Address of the setup instruction |
| setup_next_pc | input | 32 | Address of the instruction following it |
| setup_imm | input | 8 | Unsigned end offset immediate |
| setup_src | input | 32 | Source operand (trip count) |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_taken | input | 1 | The retiring instruction is a taken branch or jump |
| retire_next_pc | input | 32 | Sequential successor address of the retiring instruction |
| excm | input | 1 | Exception mode is active |
| sr_wr_en | input | 1 | Special-register write strobe |
| sr_wr_sel | input | 2 | Special-register number to write |
| sr_wr_data | input | 32 | Write data |
| sr_rd_sel | input | 2 | Special-register number to read |
| sr_rd_data | output | 32 | Read data (combinational) |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_target | output | 32 | Fetch redirect address |

## Verification
The assertions assume that setup_kind, the SR selects and the retire fields are meaningful only while their strobes are high. They also assume that nothing outside the block changes the loop registers. The redirect properties compare against the registered loop state, so they depend on every register change going through the three documented paths: setup, decrement and SR write. The stimulus drives inputs only between clock edges and returns every strobe to idle after each operation. Simultaneous events appear only in the deliberate collision tests, so every other cycle has a single cause.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  typedef enum logic [1:0] {
    KIND_ALWAYS  = 2'd0,
    KIND_IFZERO  = 2'd1,
    KIND_IFNPOS  = 2'd2,
    KIND_RSVD    = 2'd3
  } setup_kind_e;

  localparam int NUM_LREGS = 3;
  localparam logic [1:0] SR_BEGIN = 2'd0;
  localparam logic [1:0] SR_END   = 2'd1;
  localparam logic [1:0] SR_COUNT = 2'd2;
endpackage

// File: rtl/hwloop_setup_calc.sv
module hwloop_setup_calc #(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 8,
  parameter int INSN_LEN = 4
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] begin_val,
  output logic [ADDR_W-1:0] end_val,
  output logic [ADDR_W-1:0] count_val,
  output logic              skip
);
  import hwloop_pkg::*;
  localparam logic [ADDR_W-1:0] LEN_EXT = ADDR_W'(INSN_LEN);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

  logic src_zero;
  logic src_neg;

  assign begin_val = next_pc;
  assign end_val   = pc + {{(ADDR_W-IMM_W){1'b0}}, imm} + LEN_EXT;
  assign count_val = src - ONE;
  assign src_zero  = (src == '0);
  assign src_neg   = src[ADDR_W-1];

  always_comb begin
    unique case (setup_kind_e'(kind))
      KIND_IFZERO: skip = src_zero;
      KIND_IFNPOS: skip = src_zero | src_neg;
      default:     skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/hwloop_end_detect.sv
module hwloop_end_detect #(
  parameter int ADDR_W = 32
) (
  input  logic              retire_valid,
  input  logic              retire_taken,
  input  logic              excm,
  input  logic [ADDR_W-1:0] retire_next_pc,
  input  logic [ADDR_W-1:0] end_q,
  input  logic [ADDR_W-1:0] count_q,
  output logic              loop_hit,
  output logic [ADDR_W-1:0] count_dec
);
  logic seq_retire;
  logic at_end;
  logic more_left;

  assign seq_retire = retire_valid & ~retire_taken;
  assign at_end     = (retire_next_pc == end_q);
  assign more_left  = (count_q != '0);
  assign loop_hit   = seq_retire & at_end & more_left & ~excm;
  assign count_dec  = count_q - ADDR_W'(1);
endmodule

// File: rtl/hwloop_regfile.sv
module hwloop_regfile #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setup_en,
  input  logic [ADDR_W-1:0] setup_begin,
  input  logic [ADDR_W-1:0] setup_end,
  input  logic [ADDR_W-1:0] setup_count,
  input  logic              dec_en,
  input  logic [ADDR_W-1:0] dec_val,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  output logic [ADDR_W-1:0] begin_q,
  output logic [ADDR_W-1:0] end_q,
  output logic [ADDR_W-1:0] count_q
);
  import hwloop_pkg::*;

  logic [ADDR_W-1:0] regs_q   [NUM_LREGS];
  logic [ADDR_W-1:0] setup_v  [NUM_LREGS];

  assign setup_v[SR_BEGIN] = setup_begin;
  assign setup_v[SR_END]   = setup_end;
  assign setup_v[SR_COUNT] = setup_count;

  for (genvar g = 0; g < NUM_LREGS; g++) begin : g_lreg
    localparam logic [1:0] IDX = 2'(g);
    logic wr_hit;
    logic dec_here;
    assign wr_hit   = wr_en && (wr_sel == IDX);
    if (g == int'(SR_COUNT)) begin : g_cnt
      assign dec_here = dec_en;
    end else begin : g_nocnt
      assign dec_here = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst)           regs_q[g] <= '0;
      else if (wr_hit)   regs_q[g] <= wr_data;
      else if (setup_en) regs_q[g] <= setup_v[g];
      else if (dec_here) regs_q[g] <= dec_val;
    end
  end

  assign begin_q = regs_q[SR_BEGIN];
  assign end_q   = regs_q[SR_END];
  assign count_q = regs_q[SR_COUNT];

  always_comb begin
    unique case (rd_sel)
      SR_BEGIN: rd_data = begin_q;
      SR_END:   rd_data = end_q;
      SR_COUNT: rd_data = count_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/hwloop_redirect.sv
module hwloop_redirect #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              skip,
  input  logic [ADDR_W-1:0] skip_target,
  input  logic              loop_hit,
  input  logic [ADDR_W-1:0] loop_target,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_target
);
  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid  <= 1'b0;
      redir_target <= '0;
    end else begin
      redir_valid <= skip | loop_hit;
      if (skip)          redir_target <= skip_target;
      else if (loop_hit) redir_target <= loop_target;
    end
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 8,
  parameter int INSN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setup_valid,
  input  logic [1:0]        setup_kind,
  input  logic [ADDR_W-1:0] setup_pc,
  input  logic [ADDR_W-1:0] setup_next_pc,
  input  logic [IMM_W-1:0]  setup_imm,
  input  logic [ADDR_W-1:0] setup_src,
  input  logic              retire_valid,
  input  logic              retire_taken,
  input  logic [ADDR_W-1:0] retire_next_pc,
  input  logic              excm,
  input  logic              sr_wr_en,
  input  logic [1:0]        sr_wr_sel,
  input  logic [ADDR_W-1:0] sr_wr_data,
  input  logic [1:0]        sr_rd_sel,
  output logic [ADDR_W-1:0] sr_rd_data,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_target
);
  logic [ADDR_W-1:0] new_begin, new_end, new_count;
  logic              kind_skip, skip;
  logic [ADDR_W-1:0] begin_q, end_q, count_q, count_dec;
  logic              loop_hit;

  hwloop_setup_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .INSN_LEN(INSN_LEN)) setup_i (
    .kind(setup_kind), .pc(setup_pc), .next_pc(setup_next_pc), .imm(setup_imm),
    .src(setup_src), .begin_val(new_begin), .end_val(new_end),
    .count_val(new_count), .skip(kind_skip)
  );
  assign skip = setup_valid & kind_skip;

  hwloop_end_detect #(.ADDR_W(ADDR_W)) detect_i (
    .retire_valid(retire_valid), .retire_taken(retire_taken), .excm(excm),
    .retire_next_pc(retire_next_pc), .end_q(end_q), .count_q(count_q),
    .loop_hit(loop_hit), .count_dec(count_dec)
  );

  hwloop_regfile #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .setup_en(setup_valid), .setup_begin(new_begin),
    .setup_end(new_end), .setup_count(new_count), .dec_en(loop_hit),
    .dec_val(count_dec), .wr_en(sr_wr_en), .wr_sel(sr_wr_sel),
    .wr_data(sr_wr_data), .rd_sel(sr_rd_sel), .rd_data(sr_rd_data),
    .begin_q(begin_q), .end_q(end_q), .count_q(count_q)
  );

  hwloop_redirect #(.ADDR_W(ADDR_W)) redir_i (
    .clk(clk), .rst(rst), .skip(skip), .skip_target(new_end),
    .loop_hit(loop_hit), .loop_target(begin_q),
    .redir_valid(redir_valid), .redir_target(redir_target)
  );
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              setup_valid,
  input logic [1:0]        setup_kind,
  input logic [ADDR_W-1:0] setup_pc,
  input logic [IMM_W-1:0]  setup_imm,
  input logic [ADDR_W-1:0] setup_src,
  input logic              retire_valid,
  input logic              retire_taken,
  input logic [ADDR_W-1:0] retire_next_pc,
  input logic              excm,
  input logic              sr_wr_en,
  input logic [1:0]        sr_wr_sel,
  input logic [ADDR_W-1:0] sr_wr_data,
  input logic [ADDR_W-1:0] begin_q,
  input logic [ADDR_W-1:0] end_q,
  input logic [ADDR_W-1:0] count_q,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_target
);
  logic skip_c;
  logic [ADDR_W-1:0] exp_end;
  assign skip_c = setup_valid &&
                  ((setup_kind == 2'd1 && setup_src == '0) ||
                   (setup_kind == 2'd2 && $signed(setup_src) <= 0));
  assign exp_end = setup_pc + ADDR_W'(setup_imm) + ADDR_W'(4);

  p_skip_target_r5: assert property (@(posedge clk) disable iff (rst)
    skip_c |=> (redir_valid && redir_target == $past(exp_end)));

  p_loopback_r6: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && !retire_taken && !excm && !skip_c &&
     retire_next_pc == end_q && count_q != '0)
    |=> (redir_valid && redir_target == $past(begin_q)));

  p_zero_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0 && !setup_valid && !(sr_wr_en && sr_wr_sel == 2'd2))
    |=> count_q == '0);

  p_taken_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (retire_taken && !skip_c) |=> !redir_valid);

  p_excm_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (excm && !skip_c) |=> !redir_valid);

  p_srwr_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_en && sr_wr_sel == 2'd2) |=> count_q == $past(sr_wr_data));

  p_redir_cause_r6: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> $past(setup_valid || retire_valid));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) chk_i (
  .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_kind(setup_kind),
  .setup_pc(setup_pc), .setup_imm(setup_imm), .setup_src(setup_src),
  .retire_valid(retire_valid), .retire_taken(retire_taken),
  .retire_next_pc(retire_next_pc), .excm(excm), .sr_wr_en(sr_wr_en),
  .sr_wr_sel(sr_wr_sel), .sr_wr_data(sr_wr_data), .begin_q(begin_q),
  .end_q(end_q), .count_q(count_q), .redir_valid(redir_valid),
  .redir_target(redir_target)
);

// File: tb/hwloop_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic setup_valid; logic [1:0] setup_kind;
  logic [31:0] setup_pc, setup_next_pc, setup_src;
  logic [7:0] setup_imm;
  logic retire_valid, retire_taken, excm;
  logic [31:0] retire_next_pc;
  logic sr_wr_en; logic [1:0] sr_wr_sel; logic [31:0] sr_wr_data;
  logic [1:0] sr_rd_sel; logic [31:0] sr_rd_data;
  logic redir_valid; logic [31:0] redir_target;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hwloop_ctrl dut_i (
    .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_kind(setup_kind),
    .setup_pc(setup_pc), .setup_next_pc(setup_next_pc), .setup_imm(setup_imm),
    .setup_src(setup_src), .retire_valid(retire_valid), .retire_taken(retire_taken),
    .retire_next_pc(retire_next_pc), .excm(excm), .sr_wr_en(sr_wr_en),
    .sr_wr_sel(sr_wr_sel), .sr_wr_data(sr_wr_data), .sr_rd_sel(sr_rd_sel),
    .sr_rd_data(sr_rd_data), .redir_valid(redir_valid), .redir_target(redir_target)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    setup_valid = 0; setup_kind = 0; setup_pc = 0; setup_next_pc = 0;
    setup_imm = 0; setup_src = 0; retire_valid = 0; retire_taken = 0;
    retire_next_pc = 0; excm = 0; sr_wr_en = 0; sr_wr_sel = 0; sr_wr_data = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    sr_rd_sel = sel; #0.5; v = sr_rd_data;
  endtask

  task automatic setup(input logic [1:0] k, input logic [31:0] pc, input logic [31:0] npc,
                       input logic [7:0] imm, input logic [31:0] src);
    setup_valid = 1; setup_kind = k; setup_pc = pc; setup_next_pc = npc;
    setup_imm = imm; setup_src = src;
    tick(); idle();
  endtask

  task automatic retire(input logic [31:0] npc, input logic taken, input logic ex);
    retire_valid = 1; retire_next_pc = npc; retire_taken = taken; excm = ex;
    tick(); idle();
  endtask

  task automatic srw(input logic [1:0] sel, input logic [31:0] d);
    sr_wr_en = 1; sr_wr_sel = sel; sr_wr_data = d;
    tick(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(); sr_rd_sel = 0; rst = 1;
    repeat (3) tick();
    rst = 0; tick();

    // R1 reset state
    rd(0, v); chk("R1 begin", v, 0);
    rd(1, v); chk("R1 end", v, 0);
    rd(2, v); chk("R1 count", v, 0);
    chk("R1 redir", {31'b0, redir_valid}, 0);
    retire(32'h0, 0, 0);
    chk("R1 no loop after reset", {31'b0, redir_valid}, 0);

    // R2 R3 R4 basic setup with immediate zero-extension
    setup(2'd0, 32'h1000, 32'h1003, 8'hFF, 32'd7);
    chk("R5 always no skip", {31'b0, redir_valid}, 0);
    rd(0, v); chk("R3 begin", v, 32'h1003);
    rd(1, v); chk("R2 end", v, 32'h1000 + 32'hFF + 4);
    rd(2, v); chk("R4 count", v, 32'd6);

    // R5 R4 near-exhaustive sweep over kinds and small signed sources
    for (int k = 0; k < 4; k++) begin
      for (int s = -3; s <= 3; s++) begin
        logic exp_skip;
        logic [31:0] pc;
        pc = 32'h2000 + 32'(k * 64) + 32'(s + 3);
        exp_skip = (k == 1) ? (s == 0) : (k == 2) ? (s <= 0) : 1'b0;
        setup(2'(k), pc, pc + 2, 8'(s + 10), 32'(s));
        chk("R5 skip valid", {31'b0, redir_valid}, {31'b0, exp_skip});
        if (exp_skip) chk("R5 skip target", redir_target, pc + 32'(s + 10) + 4);
        rd(2, v); chk("R4 count sweep", v, 32'(s) - 1);
        tick();
        chk("R5 pulse one cycle", {31'b0, redir_valid}, 0);
      end
    end

    // R6 R7 full loops for trip counts 1..6
    for (int n = 1; n <= 6; n++) begin
      int backs;
      logic [31:0] endv;
      backs = 0;
      endv = 32'h4000 + 32'(n) * 32'h10 + 32'h20 + 4;
      setup(2'd0, 32'h4000 + 32'(n) * 32'h10, 32'h4003 + 32'(n) * 32'h10, 8'h20, 32'(n));
      for (int it = 0; it < n + 2; it++) begin
        retire(endv, 0, 0);
        if (redir_valid) begin
          backs++;
          chk("R6 target begin", redir_target, 32'h4003 + 32'(n) * 32'h10);
        end
      end
      chk("R6 loop-back count", 32'(backs), 32'(n - 1));
      rd(2, v); chk("R7 count held at zero", v, 0);
    end

    // R6 decrement step and non-end address
    setup(2'd0, 32'h5000, 32'h5003, 8'h08, 32'd4);
    retire(32'h5004, 0, 0);
    chk("R6 not at end", {31'b0, redir_valid}, 0);
    retire(32'h500C, 0, 0);
    rd(2, v); chk("R6 decrement", v, 32'd2);

    // R8 taken branch ignored
    retire(32'h500C, 1, 0);
    chk("R8 taken no redirect", {31'b0, redir_valid}, 0);
    rd(2, v); chk("R8 count unchanged", v, 32'd2);

    // R9 exception mode suppresses
    retire(32'h500C, 0, 1);
    chk("R9 excm no redirect", {31'b0, redir_valid}, 0);
    rd(2, v); chk("R9 count unchanged", v, 32'd2);

    // R10 move the end register
    srw(2'd1, 32'h6000);
    rd(1, v); chk("R10 end written", v, 32'h6000);
    retire(32'h500C, 0, 0);
    chk("R10 old end ignored", {31'b0, redir_valid}, 0);
    retire(32'h6000, 0, 0);
    chk("R10 new end loops", {31'b0, redir_valid}, 1);
    srw(2'd0, 32'h1234); rd(0, v); chk("R10 begin written", v, 32'h1234);
    srw(2'd2, 32'd9);    rd(2, v); chk("R10 count written", v, 32'd9);
    rd(3, v); chk("R10 sel3 reads zero", v, 0);

    // R11 skip collides with loop-back
    setup(2'd0, 32'h7000, 32'h7003, 8'h10, 32'd3); // end 0x7014 count 2
    setup_valid = 1; setup_kind = 2'd1; setup_pc = 32'h8000; setup_next_pc = 32'h8003;
    setup_imm = 8'h40; setup_src = 0;
    retire_valid = 1; retire_next_pc = 32'h7014;
    tick(); idle();
    chk("R11 redirect", {31'b0, redir_valid}, 1);
    chk("R11 skip target wins", redir_target, 32'h8044);
    rd(2, v); chk("R11 setup count wins", v, 32'hFFFF_FFFF);

    // R12 SR write vs decrement and vs setup
    setup(2'd0, 32'h9000, 32'h9003, 8'h10, 32'd5); // end 0x9014 count 4
    retire_valid = 1; retire_next_pc = 32'h9014;
    sr_wr_en = 1; sr_wr_sel = 2'd2; sr_wr_data = 32'd20;
    tick(); idle();
    chk("R12 loop still redirects", {31'b0, redir_valid}, 1);
    rd(2, v); chk("R12 write beats decrement", v, 32'd20);
    setup_valid = 1; setup_kind = 0; setup_pc = 32'hA000; setup_next_pc = 32'hA003;
    setup_imm = 8'h04; setup_src = 32'd2;
    sr_wr_en = 1; sr_wr_sel = 2'd0; sr_wr_data = 32'hBEEF;
    tick(); idle();
    rd(0, v); chk("R12 write beats setup", v, 32'hBEEF);
    rd(1, v); chk("R12 other regs from setup", v, 32'hA008);

    // R1 reset mid-loop
    rst = 1; tick(); rst = 0;
    rd(2, v); chk("R1 reset clears count", v, 0);
    chk("R1 reset drops redirect", {31'b0, redir_valid}, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule